// File: doc/BRIEF.md
# Cascadable Period-Match Timer Pair

The block holds two up-counting timers of one byte each. Each timer has its own period register. In separate mode, each timer has its own clock choice and its own enable. When a timer's value equals its period, the next counting tick reloads it with zero and raises that timer's sticky interrupt flag. When the chain bit is set and both enables are on, the two timers act as one 16-bit counter. The high timer forms the upper byte, and the counter is compared with a 16-bit period built from the two period registers in the same way. In that case the low timer's clock choice and enable govern the whole counter, and a wrap raises only the low flag.

A timer can count on either of two clocks. One is a free-running instruction-cycle tick pulse. The other is the falling edges of an asynchronous external pin, which the block synchronises and edge-detects first. A host reaches every timer, period, control and flag register through a small register port with a write strobe and a combinational read path. A host write to a timer byte overrides a counting tick in the same cycle. A flag stays set until the host writes a one to its bit.

Top module: `tmrpair_top`

## Requirements
- R1: Register map: address 0 is the low timer, 1 the high timer, 2 the low period, 3 the high period, 4 control and 5 flags. Control bits are: bit0 external select low, bit1 external select high, bit2 enable low, bit3 enable high, bit4 chain. Flag bits are: bit0 low flag, bit1 high flag. Reads are combinational. Reset clears control and flags, and leaves timer and period values unchanged.
- R2: With its external select at 0 and its enable set, a timer advances by one on each cycle in which `cycTick` is high.
- R3: In separate mode, a counting tick that finds a timer equal to its period loads zero into that timer and sets its own flag.
- R4: With chain, enable low and enable high all set, the high:low pair counts as one 16-bit value with a carry between the bytes. On the tick after it equals high-period:low-period, it loads zero and sets only flag bit0.
- R5: In chain mode only control bit0 selects the clock. Bit1 is ignored.
- R6: With external select set, the timer advances once for each falling edge of `extClkPin`, on the third rising clock edge after the pin change. Rising edges and a pin held low do not advance it.
- R7: In chain mode with only enable low set, the low byte counts as a separate 8-bit timer against the low period and the high byte holds. With enable low clear, both bytes hold.
- R8: A host write to a timer byte in the same cycle as a counting tick leaves the written value in that byte.
- R9: A flag stays set until the host writes 1 to its bit at address 5. Writing 0 leaves it set. A set and a clear in the same cycle leave it set.
- R10: With a period of zero, every counting tick keeps the timer at zero and sets the flag.
- R11: A timer that receives no tick and no write keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycTick | input | 1 | Instruction-cycle tick pulse |
| extClkPin | input | 1 | Asynchronous external count clock |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 3 | Host register address |
| hostWrData | input | HALF_W | Host write data |
| hostRdData | output | HALF_W | Host read data (combinational) |
| irqLo | output | 1 | Low timer flag |
| irqHi | output | 1 | High timer flag |

## Verification
Two pairs of functions can fall in the same cycle. The first is a host write to a timer byte and a counting tick on that byte. The second is a hardware flag set from a period match and a host write-one clear of that flag. The bench provokes each pair by raising `cycTick` and `hostWrEn` on the same clock edge. It then judges the result at the register port: the timer must hold the written value, and the flag must stay set.

// File: rtl/tmrpair_pkg.sv
package tmrpair_pkg;
  localparam int unsigned TP_ADDR_W = 3;
  localparam int unsigned TP_CTRL_W = 5;

  localparam logic [TP_ADDR_W-1:0] A_TMR_LO = 3'd0;
  localparam logic [TP_ADDR_W-1:0] A_TMR_HI = 3'd1;
  localparam logic [TP_ADDR_W-1:0] A_PER_LO = 3'd2;
  localparam logic [TP_ADDR_W-1:0] A_PER_HI = 3'd3;
  localparam logic [TP_ADDR_W-1:0] A_CTRL   = 3'd4;
  localparam logic [TP_ADDR_W-1:0] A_FLAGS  = 3'd5;

  localparam int unsigned CB_SEL_LO = 0;
  localparam int unsigned CB_SEL_HI = 1;
  localparam int unsigned CB_EN_LO  = 2;
  localparam int unsigned CB_EN_HI  = 3;
  localparam int unsigned CB_CHAIN  = 4;

  typedef struct packed {
    logic [1:0] tick;
    logic       wide;
    logic [1:0] wrTmr;
    logic [1:0] wrPer;
  } tpStrobe_t;
endpackage

// File: rtl/tmrpair_dp.sv
module tmrpair_dp
  import tmrpair_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tpStrobe_t              strb,
  input  logic [HALF_W-1:0]      wrData,
  output logic [1:0][HALF_W-1:0] tmrVal,
  output logic [1:0][HALF_W-1:0] perVal,
  output logic [1:0]             evt
);
  localparam int unsigned FULL_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] ONE_H = 1;
  localparam logic [FULL_W-1:0] ONE_F = 1;

  logic [1:0][HALF_W-1:0] tmr, per, nxt;
  logic [1:0]             hit;
  logic [FULL_W-1:0]      wideVal, widePer, wideNxt;
  logic                   wideHit;

  assign wideVal = {tmr[1], tmr[0]};
  assign widePer = {per[1], per[0]};
  assign wideHit = (wideVal == widePer);
  assign wideNxt = wideHit ? '0 : wideVal + ONE_F;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign hit[h] = (tmr[h] == per[h]);
    assign nxt[h] = strb.wrTmr[h] ? wrData :
                    strb.wide     ? (strb.tick[0] ? wideNxt[h*HALF_W +: HALF_W] : tmr[h]) :
                    strb.tick[h]  ? (hit[h] ? '0 : tmr[h] + ONE_H) : tmr[h];
  end

  assign evt[0] = strb.tick[0] & (strb.wide ? wideHit : hit[0]);
  assign evt[1] = strb.tick[1] & ~strb.wide & hit[1];

  // Timer and period bytes carry no reset: they keep their contents across reset.
  always_ff @(posedge clk) begin
    tmr <= nxt;
    for (int h = 0; h < 2; h++) begin
      if (strb.wrPer[h]) per[h] <= wrData;
    end
  end

  assign tmrVal = tmr;
  assign perVal = per;

  assert_inc_lo_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick[0] && !strb.wide && !strb.wrTmr[0] && !hit[0]) |=> tmr[0] == $past(tmr[0]) + ONE_H);
  assert_reload_lo_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick[0] && !strb.wide && !strb.wrTmr[0] && hit[0]) |=> tmr[0] == '0);
  assert_reload_hi_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick[1] && !strb.wide && !strb.wrTmr[1] && hit[1]) |=> tmr[1] == '0);
  assert_wide_inc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wide && strb.tick[0] && strb.wrTmr == 2'b00 && !wideHit) |=> {tmr[1], tmr[0]} == $past(wideVal) + ONE_F);
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTmr[0] |=> tmr[0] == $past(wrData));
  assert_hold_lo_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick[0] && !strb.wrTmr[0]) |=> $stable(tmr[0]));
  assert_hold_hi_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick[1] && !(strb.wide && strb.tick[0]) && !strb.wrTmr[1]) |=> $stable(tmr[1]));
endmodule

// File: rtl/tmrpair_ctrl.sv
module tmrpair_ctrl
  import tmrpair_pkg::*;
#(
  parameter int unsigned HALF_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cycTick,
  input  logic                   extClkPin,
  input  logic                   hostWrEn,
  input  logic [TP_ADDR_W-1:0]   hostAddr,
  input  logic [HALF_W-1:0]      hostWrData,
  input  logic [1:0][HALF_W-1:0] tmrVal,
  input  logic [1:0][HALF_W-1:0] perVal,
  input  logic [1:0]             evt,
  output tpStrobe_t              strb,
  output logic [HALF_W-1:0]      hostRdData,
  output logic [1:0]             flags
);
  logic [SYNC_STAGES:0]   syncSh;
  logic                   extFall;
  logic [TP_CTRL_W-1:0]   ctrlReg;
  logic [1:0]             flagReg;
  logic [1:0]             clrMask;
  logic                   wrCtrl, wrFlags;
  logic                   unusedWrBits;

  assign unusedWrBits = ^hostWrData;

  // Synchroniser chain; the extra top stage holds the previous synchronised level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncSh <= '0;
    else       syncSh <= {syncSh[SYNC_STAGES-1:0], extClkPin};
  end
  assign extFall = syncSh[SYNC_STAGES] & ~syncSh[SYNC_STAGES-1];

  assign wrCtrl  = hostWrEn && (hostAddr == A_CTRL);
  assign wrFlags = hostWrEn && (hostAddr == A_FLAGS);
  assign clrMask = wrFlags ? hostWrData[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      flagReg <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= hostWrData[TP_CTRL_W-1:0];
      flagReg <= (flagReg & ~clrMask) | evt;
    end
  end

  logic tickSrcLo, tickSrcHi;
  assign tickSrcLo = ctrlReg[CB_SEL_LO] ? extFall : cycTick;
  assign tickSrcHi = ctrlReg[CB_SEL_HI] ? extFall : cycTick;

  always_comb begin
    strb          = '0;
    strb.tick[0]  = ctrlReg[CB_EN_LO] & tickSrcLo;
    strb.tick[1]  = ~ctrlReg[CB_CHAIN] & ctrlReg[CB_EN_HI] & tickSrcHi;
    strb.wide     = ctrlReg[CB_CHAIN] & ctrlReg[CB_EN_LO] & ctrlReg[CB_EN_HI];
    strb.wrTmr[0] = hostWrEn && (hostAddr == A_TMR_LO);
    strb.wrTmr[1] = hostWrEn && (hostAddr == A_TMR_HI);
    strb.wrPer[0] = hostWrEn && (hostAddr == A_PER_LO);
    strb.wrPer[1] = hostWrEn && (hostAddr == A_PER_HI);
  end

  always_comb begin
    case (hostAddr)
      A_TMR_LO: hostRdData = tmrVal[0];
      A_TMR_HI: hostRdData = tmrVal[1];
      A_PER_LO: hostRdData = perVal[0];
      A_PER_HI: hostRdData = perVal[1];
      A_CTRL:   hostRdData = HALF_W'(ctrlReg);
      A_FLAGS:  hostRdData = HALF_W'(flagReg);
      default:  hostRdData = '0;
    endcase
  end

  assign flags = flagReg;

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    evt[0] |=> flagReg[0]);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg[1] && !clrMask[1]) |=> flagReg[1]);
  assert_fall_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    extFall |=> !extFall);
  assert_chain_hi_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[CB_CHAIN] && !strb.wrTmr[1] && !strb.wide) |=> $stable(tmrVal[1]));
endmodule

// File: rtl/tmrpair_top.sv
module tmrpair_top
  import tmrpair_pkg::*;
#(
  parameter int unsigned HALF_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cycTick,
  input  logic                 extClkPin,
  input  logic                 hostWrEn,
  input  logic [TP_ADDR_W-1:0] hostAddr,
  input  logic [HALF_W-1:0]    hostWrData,
  output logic [HALF_W-1:0]    hostRdData,
  output logic                 irqLo,
  output logic                 irqHi
);
  tpStrobe_t              strb;
  logic [1:0][HALF_W-1:0] tmrVal, perVal;
  logic [1:0]             evt, flags;

  tmrpair_ctrl #(.HALF_W(HALF_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cycTick(cycTick), .extClkPin(extClkPin),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .tmrVal(tmrVal), .perVal(perVal), .evt(evt),
    .strb(strb), .hostRdData(hostRdData), .flags(flags)
  );

  tmrpair_dp #(.HALF_W(HALF_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(hostWrData),
    .tmrVal(tmrVal), .perVal(perVal), .evt(evt)
  );

  assign irqLo = flags[0];
  assign irqHi = flags[1];
endmodule

// File: tb/tmrpair_tb_top.sv
module tmrpair_tb_top;
  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycTick = 1'b0;
  logic       extClkPin = 1'b1;
  logic       hostWrEn = 1'b0;
  logic [2:0] hostAddr = 3'd0;
  logic [7:0] hostWrData = 8'd0;
  logic [7:0] hostRdData;
  logic       irqLo, irqHi;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;
  string      tagQ[$];
  logic [7:0] expQ[$];
  event       chkEv;

  always #(CLK_NS/2) clk = ~clk;

  tmrpair_top dut_i (
    .clk(clk), .rstN(rstN), .cycTick(cycTick), .extClkPin(extClkPin),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .irqLo(irqLo), .irqHi(irqHi)
  );

  // Monitor: pops one expected item per request and compares it with the read port.
  initial begin
    forever begin
      @(chkEv);
      #2;
      begin
        string      t;
        logic [7:0] e;
        t = tagQ.pop_front();
        e = expQ.pop_front();
        total++;
        if (hostRdData !== e) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", t, hostRdData, e);
        end
      end
    end
  end

  task automatic expectReg(input string tag, input logic [2:0] a, input logic [7:0] e);
    @(negedge clk);
    hostAddr = a;
    tagQ.push_back(tag);
    expQ.push_back(e);
    ->chkEv;
    wait (expQ.size() == 0);
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cycTick = 1'b1;
      @(negedge clk); cycTick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic tickWithWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cycTick = 1'b1; hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    cycTick = 1'b0; hostWrEn = 1'b0;
  endtask

  task automatic pulseReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state and retention across reset
    expectReg("R1 control after reset", 3'd4, 8'h00);
    expectReg("R1 flags after reset", 3'd5, 8'h00);
    hostWrite(3'd0, 8'h5A);
    hostWrite(3'd3, 8'h33);
    hostWrite(3'd4, 8'h1F);
    pulseReset();
    expectReg("R1 low timer kept over reset", 3'd0, 8'h5A);
    expectReg("R1 high period kept over reset", 3'd3, 8'h33);
    expectReg("R1 control cleared by reset", 3'd4, 8'h00);

    // R2/R3 separate low timer
    hostWrite(3'd1, 8'h10);
    hostWrite(3'd0, 8'h00);
    hostWrite(3'd2, 8'h05);
    hostWrite(3'd4, 8'h04);
    ticks(3);
    expectReg("R2 low timer after 3 ticks", 3'd0, 8'h03);
    ticks(2);
    expectReg("R2 low timer at period", 3'd0, 8'h05);
    expectReg("R3 no flag before reload", 3'd5, 8'h00);
    ticks(1);
    expectReg("R3 low reload to zero", 3'd0, 8'h00);
    expectReg("R3 low flag set", 3'd5, 8'h01);
    expectReg("R11 disabled high timer holds", 3'd1, 8'h10);
    ticks(1);
    expectReg("R9 flag sticky", 3'd5, 8'h01);
    hostWrite(3'd5, 8'h01);
    expectReg("R9 flag cleared by write-one", 3'd5, 8'h00);

    // R3 separate high timer
    hostWrite(3'd4, 8'h08);
    hostWrite(3'd1, 8'hFE);
    hostWrite(3'd3, 8'hFF);
    ticks(1);
    expectReg("R3 high timer counts", 3'd1, 8'hFF);
    ticks(1);
    expectReg("R3 high reload", 3'd1, 8'h00);
    expectReg("R3 high flag bit1", 3'd5, 8'h02);
    expectReg("R11 disabled low timer holds", 3'd0, 8'h01);
    hostWrite(3'd5, 8'h02);

    // R10 zero period
    hostWrite(3'd4, 8'h04);
    hostWrite(3'd0, 8'h00);
    hostWrite(3'd2, 8'h00);
    ticks(1);
    expectReg("R10 zero period stays zero", 3'd0, 8'h00);
    expectReg("R10 zero period flags", 3'd5, 8'h01);
    hostWrite(3'd5, 8'h01);
    ticks(1);
    expectReg("R10 zero period flags again", 3'd5, 8'h01);
    hostWrite(3'd5, 8'h01);

    // R4 chained 16-bit
    hostWrite(3'd4, 8'h1C);
    hostWrite(3'd0, 8'hFE);
    hostWrite(3'd1, 8'h00);
    hostWrite(3'd2, 8'h01);
    hostWrite(3'd3, 8'h01);
    ticks(1);
    expectReg("R4 wide low FF", 3'd0, 8'hFF);
    ticks(1);
    expectReg("R4 wide carry low", 3'd0, 8'h00);
    expectReg("R4 wide carry high", 3'd1, 8'h01);
    ticks(1);
    expectReg("R4 wide at period no flag", 3'd5, 8'h00);
    ticks(1);
    expectReg("R4 wide reload low", 3'd0, 8'h00);
    expectReg("R4 wide reload high", 3'd1, 8'h00);
    expectReg("R4 wide flag bit0 only", 3'd5, 8'h01);
    hostWrite(3'd5, 8'h01);

    // R5 high clock select ignored in chain
    hostWrite(3'd4, 8'h1E);
    ticks(2);
    expectReg("R5 high select ignored", 3'd0, 8'h02);
    hostWrite(3'd4, 8'h1D);
    ticks(2);
    expectReg("R5 low select picks external", 3'd0, 8'h02);

    // R6 external falling edge, three-edge latency
    @(negedge clk); extClkPin = 1'b0;
    @(negedge clk);
    expectReg("R6 not yet after two edges", 3'd0, 8'h02);
    expectReg("R6 advanced on third edge", 3'd0, 8'h03);
    repeat (6) @(negedge clk);
    extClkPin = 1'b1;
    repeat (6) @(negedge clk);
    expectReg("R6 no count on low level or rise", 3'd0, 8'h03);
    expectReg("R6 high byte", 3'd1, 8'h00);

    // R7 mismatched enables in chain
    hostWrite(3'd4, 8'h14);
    hostWrite(3'd0, 8'h00);
    hostWrite(3'd1, 8'h07);
    hostWrite(3'd2, 8'h02);
    ticks(3);
    expectReg("R7 low-only wraps at low period", 3'd0, 8'h00);
    expectReg("R7 low-only high holds", 3'd1, 8'h07);
    expectReg("R7 low-only flag", 3'd5, 8'h01);
    hostWrite(3'd5, 8'h01);
    hostWrite(3'd4, 8'h18);
    ticks(2);
    expectReg("R7 low enable clear stops low", 3'd0, 8'h00);
    expectReg("R7 low enable clear stops high", 3'd1, 8'h07);

    // R8 write beats tick; R9 set beats clear
    hostWrite(3'd4, 8'h04);
    hostWrite(3'd2, 8'hFF);
    hostWrite(3'd0, 8'h10);
    tickWithWrite(3'd0, 8'h40);
    expectReg("R8 write wins over tick", 3'd0, 8'h40);
    hostWrite(3'd2, 8'h40);
    tickWithWrite(3'd5, 8'h01);
    expectReg("R9 set wins over clear", 3'd5, 8'h01);
    expectReg("R3 reload in same cycle", 3'd0, 8'h00);
    hostWrite(3'd5, 8'h00);
    expectReg("R9 write zero keeps flag", 3'd5, 8'h01);
    hostWrite(3'd5, 8'h01);
    expectReg("R9 final clear", 3'd5, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule